// File: doc/BRIEF.md
# Serial Memory Command and Read Engine

This block is the slave-side front end of a byte-addressed serial memory of 131,072 bytes. While the chip select is low it shifts in an 8-bit opcode, most significant bit first, on rising serial-clock edges. A read opcode is followed by a 24-bit address. The engine then streams bytes from an internal content model, most significant bit first, and advances the address after every byte. Every other recognised opcode is handed to the write and erase logic as a one-cycle strobe. The rest of that transaction is then ignored.

All serial inputs are sampled by the block's own system clock through a configurable synchroniser. The engine detects serial-clock edges in that domain, so the system clock must run several times faster than the serial clock. A pause input freezes the transaction without losing its place. The data output is reported as a value plus an enable that a pad cell turns into a three-state driver. A busy input from the write controller makes the engine refuse array reads.

Top module: `spi_mem_read_engine`

## Requirements
- R1: After reset, so_oe and cmd_valid are 0.
- R2: Opcode and address bits are taken on rising edges of sck, MSB first, starting with the first rising edge after cs_n falls. Both idle-low (mode 0) and idle-high (mode 3) clocks work.
- R3: The read opcode is 0x03. The 24 address bits that follow it arrive MSB first. Only the low 17 bits select a byte; the upper 7 bits have no effect on the data returned.
- R4: After the last address bit, each falling edge of sck drives the next data bit, MSB first. The first falling edge after the last address bit drives bit 7 of the first byte. The byte stored at address A (17 bits) is A[7:0] ^ A[15:8] ^ {7'b0, A[16]} ^ 8'hA5.
- R5: After each byte is sent, the address increments. Address 0x1FFFF is followed by 0x00000.
- R6: so_oe is 1 only in the data phase of a read, after its first data bit has been driven, while cs_n is low. Raising cs_n clears so_oe and ends the read. The next transaction starts again with an opcode.
- R7: While hold_n is low, sck and si edges are ignored and so_oe is 0. After hold_n returns high, so_out shows the same bit as before the pause, and the transfer continues from that bit.
- R8: A read opcode received while busy is 1 is refused. No data is driven for that transaction, and no strobe is raised.
- R9: The opcodes 0x01, 0x02, 0x04, 0x05, 0x06, 0x42, 0xD8, 0xC7, 0xAB and 0xB9 each raise cmd_valid for one clock with cmd_code equal to the opcode. The remaining bits of that transaction are ignored.
- R10: Any other opcode raises no strobe. The engine then ignores all bits until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| busy | input | 1 | High while an internal write cycle runs |
| so_out | output | 1 | Serial data out value, 0 while not enabled |
| so_oe | output | 1 | Output enable for the serial data pad |
| cmd_valid | output | 1 | One-clock strobe for a decoded non-read opcode |
| cmd_code | output | 8 | Opcode that goes with cmd_valid |

## Verification
Reads are tried at low addresses, at addresses with upper don't-care bits set, and across the top of the array. These cases separate a correct 17-bit pointer from one that keeps too many bits or fails to wrap. The same read is repeated with an idle-low and an idle-high clock, which exposes off-by-one-edge errors in the first data bit. A pause in the middle of a byte, with clock pulses during the pause, shows whether those edges are truly ignored. The bench also sends all ten pass-on opcodes, several unknown opcodes, a read while busy, and a read cut short by chip select. These cases separate strobe decoding from read handling and show that a transaction which was ignored never drives the pad.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

   typedef enum logic [7:0] {
      OP_STAT_WR = 8'h01,
      OP_PROGRAM = 8'h02,
      OP_READ    = 8'h03,
      OP_WE_CLR  = 8'h04,
      OP_STAT_RD = 8'h05,
      OP_WE_SET  = 8'h06,
      OP_PG_ERA  = 8'h42,
      OP_SEC_ERA = 8'hD8,
      OP_ALL_ERA = 8'hC7,
      OP_ID_WAKE = 8'hAB,
      OP_SLEEP   = 8'hB9
   } op_e;

   typedef enum logic [1:0] {
      PH_OPC,
      PH_ADDR,
      PH_DATA,
      PH_SKIP
   } phase_e;

   // opcodes handed on to the write / erase logic
   function automatic logic is_passed(input logic [7:0] op);
      case (op)
         OP_STAT_WR, OP_PROGRAM, OP_WE_CLR, OP_STAT_RD, OP_WE_SET,
         OP_PG_ERA, OP_SEC_ERA, OP_ALL_ERA, OP_ID_WAKE, OP_SLEEP: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // computed stand-in for the array contents
   function automatic logic [7:0] fold_byte(input logic [23:0] a, input logic [7:0] seed);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ seed;
   endfunction

endpackage

// File: rtl/spi_in_sampler.sv
module spi_in_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   output logic desel,
   output logic hold_ok,
   output logic si_s,
   output logic sck_rise,
   output logic sck_fall
);
   localparam int NSIG = 4;
   localparam logic [NSIG-1:0] IDLE = 4'b1100;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("spi_in_sampler: SYNC_STAGES must be 1 to 4");
   end

   logic [NSIG-1:0] raw, cur;
   logic            sck_d;

   assign raw = {cs_n, hold_n, sck, si};

   if (SYNC_STAGES == 1) begin : g_one
      logic [NSIG-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= IDLE;
         else        r <= raw;
      end
      assign cur = r;
   end else begin : g_chain
      logic [SYNC_STAGES-1:0][NSIG-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= {SYNC_STAGES{IDLE}};
         else        r <= {r[SYNC_STAGES-2:0], raw};
      end
      assign cur = r[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= cur[1];
   end

   logic active;
   assign desel    = cur[3];
   assign hold_ok  = cur[2];
   assign si_s     = cur[0];
   assign active   = !cur[3] && cur[2];
   assign sck_rise = active &&  cur[1] && !sck_d;
   assign sck_fall = active && !cur[1] &&  sck_d;

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_eng_pkg::*;
#(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desel,
   input  logic              rise,
   input  logic              si,
   input  logic              busy,
   output phase_e            phase,
   output logic [4:0]        bit_cnt,
   output logic              cmd_valid,
   output logic [7:0]        cmd_code,
   output logic              start,
   output logic [ADDR_W-1:0] start_addr
);
   localparam int OPC_BITS = 8;
   localparam int ADR_BITS = 24;
   localparam int CNT_W    = 5;

   logic [ADR_BITS-1:0] sh, shifted;
   assign shifted = {sh[ADR_BITS-2:0], si};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_OPC;
         bit_cnt    <= '0;
         sh         <= '0;
         cmd_valid  <= 1'b0;
         cmd_code   <= '0;
         start      <= 1'b0;
         start_addr <= '0;
      end else begin
         cmd_valid <= 1'b0;
         start     <= 1'b0;
         if (desel) begin
            phase   <= PH_OPC;
            bit_cnt <= '0;
         end else if (rise) begin
            case (phase)
               PH_OPC: begin
                  sh <= shifted;
                  if (bit_cnt == CNT_W'(OPC_BITS - 1)) begin
                     bit_cnt <= '0;
                     if (shifted[7:0] == OP_READ) begin
                        phase <= busy ? PH_SKIP : PH_ADDR;
                     end else begin
                        phase <= PH_SKIP;
                        if (is_passed(shifted[7:0])) begin
                           cmd_valid <= 1'b1;
                           cmd_code  <= shifted[7:0];
                        end
                     end
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               PH_ADDR: begin
                  sh <= shifted;
                  if (bit_cnt == CNT_W'(ADR_BITS - 1)) begin
                     bit_cnt    <= '0;
                     phase      <= PH_DATA;
                     start      <= 1'b1;
                     start_addr <= shifted[ADDR_W-1:0];
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/spi_read_out.sv
module spi_read_out
   import spi_eng_pkg::*;
#(
   parameter int         ADDR_W = 17,
   parameter logic [7:0] SEED   = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              desel,
   input  logic              in_data,
   input  logic              fall,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              so_bit,
   output logic              drv,
   output logic [ADDR_W-1:0] ptr
);
   localparam int BIT_W = 3;

   logic [7:0]        cur;
   logic [BIT_W-1:0]  idx;
   logic [ADDR_W-1:0] ptr_nx;

   assign ptr_nx = ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         cur    <= '0;
         idx    <= '0;
         so_bit <= 1'b0;
         drv    <= 1'b0;
      end else if (desel) begin
         drv <= 1'b0;
      end else if (start) begin
         ptr <= start_addr;
         cur <= fold_byte(24'(start_addr), SEED);
         idx <= '0;
         drv <= 1'b0;
      end else if (fall && in_data) begin
         so_bit <= cur[3'd7 - idx];
         drv    <= 1'b1;
         idx    <= idx + 1'b1;
         if (idx == 3'd7) begin
            ptr <= ptr_nx;
            cur <= fold_byte(24'(ptr_nx), SEED);
         end
      end
   end

endmodule

// File: rtl/spi_mem_read_engine.sv
module spi_mem_read_engine
   import spi_eng_pkg::*;
#(
   parameter int         ADDR_W       = 17,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [7:0] CONTENT_SEED = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sck,
   input  logic       si,
   input  logic       hold_n,
   input  logic       busy,
   output logic       so_out,
   output logic       so_oe,
   output logic       cmd_valid,
   output logic [7:0] cmd_code
);
   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("spi_mem_read_engine: ADDR_W must be 1 to 24");
   end

   logic              desel, hold_ok, si_s, sck_rise, sck_fall;
   phase_e            phase;
   logic [4:0]        seq_cnt;
   logic              rd_start, so_bit, drv, in_data;
   logic [ADDR_W-1:0] rd_addr, rd_ptr;

   spi_in_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .desel(desel), .hold_ok(hold_ok), .si_s(si_s),
      .sck_rise(sck_rise), .sck_fall(sck_fall)
   );

   spi_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .desel(desel), .rise(sck_rise), .si(si_s),
      .busy(busy), .phase(phase), .bit_cnt(seq_cnt),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .start(rd_start), .start_addr(rd_addr)
   );

   assign in_data = (phase == PH_DATA);

   spi_read_out #(.ADDR_W(ADDR_W), .SEED(CONTENT_SEED)) u_rd (
      .clk(clk), .rst_n(rst_n), .desel(desel), .in_data(in_data),
      .fall(sck_fall), .start(rd_start), .start_addr(rd_addr),
      .so_bit(so_bit), .drv(drv), .ptr(rd_ptr)
   );

   assign so_oe  = !desel && hold_ok && drv;
   assign so_out = so_oe && so_bit;

endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              so_out,
   input logic              so_oe,
   input logic              cmd_valid,
   input logic [7:0]        cmd_code,
   input logic              fall,
   input logic              hold_ok,
   input logic              desel,
   input logic              in_data,
   input logic              start,
   input logic [ADDR_W-1:0] ptr,
   input logic [4:0]        bit_cnt
);

   // R9
   cmd_code_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_code inside {8'h01, 8'h02, 8'h04, 8'h05, 8'h06,
                                      8'h42, 8'hD8, 8'hC7, 8'hAB, 8'hB9}));

   // R9
   cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R4
   so_changes_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && $past(so_oe) && !$past(fall)) |-> $stable(so_out));

   // R6
   so_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> in_data);

   // R7
   hold_freezes_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_ok && !desel && !start) |=> ($stable(ptr) && $stable(bit_cnt)));

   // R5
   ptr_steps_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && (ptr != $past(ptr))) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));

endmodule

bind spi_mem_read_engine spi_eng_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .so_out(so_out), .so_oe(so_oe),
   .cmd_valid(cmd_valid), .cmd_code(cmd_code), .fall(sck_fall),
   .hold_ok(hold_ok), .desel(desel), .in_data(in_data),
   .start(rd_start), .ptr(rd_ptr), .bit_cnt(seq_cnt)
);

// File: tb/sim_spi_mem_read_engine.sv
`timescale 1ns/1ps
module sim_spi_mem_read_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic       si = 1'b0;
   logic       hold_n = 1'b1;
   logic       busy = 1'b0;
   logic       so_out, so_oe, cmd_valid;
   logic [7:0] cmd_code;

   int         n_chk = 0;
   int         n_bad = 0;
   int         n_strobe = 0;
   logic [7:0] last_code = 8'h00;
   logic       pend = 1'b0;
   logic       oe_any = 1'b0;

   always #10 clk = ~clk;

   spi_mem_read_engine u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .hold_n(hold_n), .busy(busy), .so_out(so_out), .so_oe(so_oe),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code)
   );

   always @(negedge clk) begin
      if (cmd_valid === 1'b1) begin
         n_strobe  = n_strobe + 1;
         last_code = cmd_code;
      end
   end

   function automatic logic [7:0] content(input int a);
      logic [16:0] m;
      m = a[16:0];
      return m[7:0] ^ m[15:8] ^ {7'b0, m[16]} ^ 8'hA5;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xbit(input logic v, output logic r);
      sck = 1'b0;
      si  = v;
      wt(6);
      sck = 1'b1;
      wt(6);
      sck = 1'b0;
      wt(6);
      r = so_out;
      oe_any = oe_any | so_oe;
   endtask

   task automatic start_txn(input bit mode3);
      sck = mode3;
      wt(6);
      cs_n = 1'b0;
      wt(6);
      oe_any   = 1'b0;
      n_strobe = 0;
   endtask

   task automatic end_txn(input bit mode3);
      wt(6);
      if (mode3) begin
         sck = 1'b1;
         wt(6);
      end
      cs_n = 1'b1;
      wt(8);
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) xbit(b[i], r);
   endtask

   task automatic send_addr(input logic [23:0] a);
      for (int i = 23; i >= 0; i--) xbit(a[i], pend);
   endtask

   task automatic read_byte(output logic [7:0] b);
      logic r;
      b[7] = pend;
      for (int i = 6; i >= 0; i--) begin
         xbit(1'b0, r);
         b[i] = r;
      end
      xbit(1'b0, pend);
   endtask

   // R1
   task automatic t_reset();
      wt(5);
      chk("R1 so_oe in reset", so_oe, 0);
      rst_n = 1'b1;
      wt(5);
      chk("R1 so_oe after reset", so_oe, 0);
      chk("R1 cmd_valid after reset", cmd_valid, 0);
   endtask

   task automatic t_read(input bit mode3, input logic [23:0] addr, input int nbytes, input string tag);
      logic [7:0] b;
      start_txn(mode3);
      send_byte(8'h03);
      chk("R6 so_oe during address", so_oe, 0);
      send_addr(addr);
      chk("R6 so_oe in data phase", so_oe, 1);
      for (int j = 0; j < nbytes; j++) begin
         read_byte(b);
         chk(tag, b, content(int'(addr) + j));
      end
      end_txn(mode3);
      chk("R6 so_oe after cs_n high", so_oe, 0);
   endtask

   // R7
   task automatic t_hold();
      logic [7:0] exp0, b0, b1;
      logic       r;
      exp0 = content(24'h000040);
      start_txn(1'b0);
      send_byte(8'h03);
      send_addr(24'h000040);
      b0[7] = pend;
      for (int i = 6; i >= 4; i--) begin
         xbit(1'b0, r);
         b0[i] = r;
      end
      hold_n = 1'b0;
      wt(6);
      chk("R7 so_oe low in hold", so_oe, 0);
      for (int k = 0; k < 2; k++) begin
         sck = 1'b1;
         wt(6);
         sck = 1'b0;
         wt(6);
      end
      chk("R7 so_oe low after clocks in hold", so_oe, 0);
      hold_n = 1'b1;
      wt(6);
      chk("R7 so_oe back after hold", so_oe, 1);
      chk("R7 bit kept across hold", so_out, exp0[4]);
      for (int i = 3; i >= 0; i--) begin
         xbit(1'b0, r);
         b0[i] = r;
      end
      xbit(1'b0, pend);
      chk("R7 byte through hold", b0, exp0);
      read_byte(b1);
      chk("R7 byte after hold", b1, content(24'h000041));
      end_txn(1'b0);
   endtask

   // R8
   task automatic t_busy();
      logic [7:0] b;
      busy = 1'b1;
      start_txn(1'b0);
      send_byte(8'h03);
      send_addr(24'h000100);
      read_byte(b);
      read_byte(b);
      end_txn(1'b0);
      chk("R8 no output while busy", oe_any, 0);
      chk("R8 no strobe for refused read", n_strobe, 0);
      busy = 1'b0;
      t_read(1'b0, 24'h000100, 1, "R8 read after busy clears");
   endtask

   // R9
   task automatic t_cmds();
      logic [7:0] ops [10] = '{8'h01, 8'h02, 8'h04, 8'h05, 8'h06,
                              8'h42, 8'hD8, 8'hC7, 8'hAB, 8'hB9};
      for (int k = 0; k < 10; k++) begin
         start_txn(k[0]);
         send_byte(ops[k]);
         send_byte(8'h03);
         send_byte(8'h00);
         end_txn(k[0]);
         chk("R9 strobe count", n_strobe, 1);
         chk("R9 strobe code", last_code, ops[k]);
         chk("R9 rest ignored", oe_any, 0);
      end
   endtask

   // R10
   task automatic t_unknown();
      logic [7:0] ops [3] = '{8'h00, 8'hFF, 8'h07};
      for (int k = 0; k < 3; k++) begin
         start_txn(1'b0);
         send_byte(ops[k]);
         send_byte(8'h03);
         send_addr(24'h000010);
         send_byte(8'h00);
         send_byte(8'h00);
         end_txn(1'b0);
         chk("R10 no strobe", n_strobe, 0);
         chk("R10 no output", oe_any, 0);
      end
   endtask

   // R6
   task automatic t_abort();
      logic [7:0] b;
      logic       r;
      start_txn(1'b0);
      send_byte(8'h03);
      send_addr(24'h000200);
      read_byte(b);
      chk("R6 first byte before abort", b, content(24'h000200));
      for (int i = 0; i < 3; i++) xbit(1'b0, r);
      end_txn(1'b0);
      chk("R6 so_oe off after abort", so_oe, 0);
      t_read(1'b0, 24'h000300, 1, "R6 fresh read after abort");
   endtask

   initial begin
      t_reset();
      t_read(1'b0, 24'h000123, 3, "R4 mode0 sequential data");
      t_read(1'b1, 24'h00A5F0, 2, "R2 mode3 sequential data");
      t_read(1'b0, 24'h01FFFE, 4, "R5 wrap at top");
      t_read(1'b0, 24'hFE0005, 1, "R3 upper bits ignored");
      t_read(1'b1, 24'h800010, 2, "R3 upper bits ignored mode3");
      t_hold();
      t_busy();
      t_cmds();
      t_unknown();
      t_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule